// File: doc/BRIEF.md
# Debug Register Scan Port

This block is the target-side end of a JTAG link that reaches a small bank of on-chip debug registers. It has a test access port state machine driven by the test clock and mode-select pins, a 4-bit instruction register and a 4-bit chain selector. The chain selector is loaded while a scan-select instruction is active. When the internal-test instruction is active and the selector holds the register chain number, the data path becomes a 38-bit register-access chain. Each scan of that chain carries a 32-bit value, a 5-bit register address and a direction flag.

A host writes a register in a single scan. A read needs two scans: the first names the register, and the second returns its contents. The control register drives three core-facing outputs: a debug request, a forced acknowledge and an interrupt mask. The status register mirrors three signals from the core. Entry into debug is not immediate. After it raises the request, the host keeps reading the status register until the core's acknowledge appears. A restart instruction raises a strobe toward the core while the port idles.

Top module: `dbgscan_top`

## Requirements
- R1: While trst_n is low, and after it rises, ack_force_o, dbg_req_o, irq_mask_o, restart_o and tdo_en are 0, and the instruction register holds the bypass code 4'hF.
- R2: While the instruction register shifts, it presents the capture pattern 4'b0001 on tdo, LSB first. The shifted-in value becomes the active instruction only at Update-IR. The codes are 4'h2 for scan-select, 4'hC for internal test, 4'h4 for restart and 4'hF for bypass.
- R3: Under bypass, or under any code without its own path, the data path is a single stage that captures 0, so tdo repeats tdi one bit later.
- R4: Under scan-select, the data path is the 4-bit chain selector. It captures the current chain number and loads the shifted value at Update-DR.
- R5: With internal test active and chain 2 selected, a scan whose bit 37 is 1 (bits 0-31 data, bits 32-36 address, LSB first) writes at Update-DR. A write to address 0 sets ack_force_o from data bit 0, dbg_req_o from bit 1 and irq_mask_o from bit 2.
- R6: A scan whose bit 37 is 0 latches its address. The next Capture-DR loads bits 0-31 with that register's value, bits 32-36 with the latched address and bit 37 with 0. A later write scan leaves the latched address unchanged. Control reads return its three bits with all upper bits 0.
- R7: Address 1 is the status register. Bit 0 is core_ack_i, bit 3 is core_sys_done_i, bit 4 is core_narrow_i, and all other bits are 0.
- R8: Addresses other than 0 and 1 read as zero. Writes to them, and writes to address 1, change no output.
- R9: Entering Test-Logic-Reset through tms clears the control register, sets the instruction to bypass and sets the chain selector to 0.
- R10: With internal test active and a chain other than 2 selected, the data path is the one-bit bypass and register scans have no effect.
- R11: restart_o is 1 exactly while the instruction is restart and the port is in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid in the shift states |
| tdo_en | output | 1 | High while a shift state drives tdo |
| core_ack_i | input | 1 | Core has entered debug |
| core_sys_done_i | input | 1 | System-speed access finished |
| core_narrow_i | input | 1 | Core was in its 16-bit instruction state |
| ack_force_o | output | 1 | Forced debug acknowledge |
| dbg_req_o | output | 1 | Debug entry request |
| irq_mask_o | output | 1 | Interrupt disable while in debug |
| restart_o | output | 1 | Restart strobe in Run-Test/Idle |

## Verification
The bench builds the block with its default parameters: 32 data bits, 5 address bits, a 4-bit chain selector and the register chain at number 2. These values make the full 38-bit chain reachable. They also reach the highest address 31 on the unimplemented side, chain 1 as a non-register selection, and random 32-bit write words whose upper 29 bits must vanish on readback. With the 4-bit instruction width, all four instruction codes and the Test-Logic-Reset return can be driven directly from the pins.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] IR_SCAN_SEL = 4'h2;
    localparam logic [IR_W-1:0] IR_RESTART  = 4'h4;
    localparam logic [IR_W-1:0] IR_INTEST   = 4'hC;
    localparam logic [IR_W-1:0] IR_BYPASS   = 4'hF;

    // control register bit positions
    localparam int CTL_ACK = 0;
    localparam int CTL_REQ = 1;
    localparam int CTL_IRQ = 2;
    localparam int CTL_W   = 3;

    // status register bit positions
    localparam int ST_ACK    = 0;
    localparam int ST_SYS    = 3;
    localparam int ST_NARROW = 4;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TLR:     n = m ? TLR    : RTI;
            RTI:     n = m ? SEL_DR : RTI;
            SEL_DR:  n = m ? SEL_IR : CAP_DR;
            CAP_DR:  n = m ? EX1_DR : SH_DR;
            SH_DR:   n = m ? EX1_DR : SH_DR;
            EX1_DR:  n = m ? UPD_DR : PAU_DR;
            PAU_DR:  n = m ? EX2_DR : PAU_DR;
            EX2_DR:  n = m ? UPD_DR : SH_DR;
            UPD_DR:  n = m ? SEL_DR : RTI;
            SEL_IR:  n = m ? TLR    : CAP_IR;
            CAP_IR:  n = m ? EX1_IR : SH_IR;
            SH_IR:   n = m ? EX1_IR : SH_IR;
            EX1_IR:  n = m ? UPD_IR : PAU_IR;
            PAU_IR:  n = m ? EX2_IR : PAU_IR;
            EX2_IR:  n = m ? UPD_IR : SH_IR;
            UPD_IR:  n = m ? SEL_DR : RTI;
            default: n = TLR;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbgscan_tap.sv
module dbgscan_tap
    import dbgscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e st_d, st_q;

    always_comb begin
        st_d = tap_next(st_q, tms);
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) st_q <= TLR;
        else         st_q <= st_d;
    end

    assign state_o = st_q;

endmodule

// File: rtl/dbgscan_ir.sv
module dbgscan_ir
    import dbgscan_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  logic             tdi,
    input  logic             byp_path,
    output logic [IR_W-1:0]  ir_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             ir_tdo,
    output logic             sel_tdo,
    output logic             byp_tdo
);

    typedef struct packed {
        logic [IR_W-1:0]  ir_sr;
        logic [IR_W-1:0]  ir;
        logic [SEL_W-1:0] sel_sr;
        logic [SEL_W-1:0] sel;
        logic             byp;
    } ir_regs_t;

    ir_regs_t r_d, r_q;
    logic     sel_path;

    assign sel_path = (r_q.ir == IR_SCAN_SEL);

    always_comb begin
        r_d = r_q;
        case (state)
            TLR: begin
                r_d.ir  = IR_BYPASS;
                r_d.sel = '0;
            end
            CAP_IR: r_d.ir_sr = IR_W'(1);
            SH_IR:  r_d.ir_sr = {tdi, r_q.ir_sr[IR_W-1:1]};
            UPD_IR: r_d.ir    = r_q.ir_sr;
            CAP_DR: begin
                if (sel_path) r_d.sel_sr = r_q.sel;
                if (byp_path) r_d.byp    = 1'b0;
            end
            SH_DR: begin
                if (sel_path) r_d.sel_sr = {tdi, r_q.sel_sr[SEL_W-1:1]};
                if (byp_path) r_d.byp    = tdi;
            end
            UPD_DR: begin
                if (sel_path) r_d.sel = r_q.sel_sr;
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q        <= '0;
            r_q.ir     <= IR_BYPASS;
            r_q.ir_sr  <= IR_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign ir_o    = r_q.ir;
    assign sel_o   = r_q.sel;
    assign ir_tdo  = r_q.ir_sr[0];
    assign sel_tdo = r_q.sel_sr[0];
    assign byp_tdo = r_q.byp;

endmodule

// File: rtl/dbgscan_regbank.sv
module dbgscan_regbank
    import dbgscan_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_e       state,
    input  logic             chain_en,
    input  logic             tdi,
    input  logic             core_ack,
    input  logic             core_sys,
    input  logic             core_narrow,
    output logic [CTL_W-1:0] ctrl_o,
    output logic             tdo_o
);

    localparam int CH_W    = DATA_W + ADDR_W + 1;
    localparam int ADDR_LO = DATA_W;
    localparam int ADDR_HI = DATA_W + ADDR_W - 1;
    localparam int DIR_BIT = CH_W - 1;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    typedef struct packed {
        logic [CH_W-1:0]   sr;
        logic [ADDR_W-1:0] rd_addr;
        logic [CTL_W-1:0]  ctrl;
    } bank_regs_t;

    bank_regs_t b_d, b_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] scan_addr;

    assign scan_addr = b_q.sr[ADDR_HI:ADDR_LO];

    always_comb begin
        stat_word            = '0;
        stat_word[ST_ACK]    = core_ack;
        stat_word[ST_SYS]    = core_sys;
        stat_word[ST_NARROW] = core_narrow;
        case (b_q.rd_addr)
            A_CTRL:  rd_word = DATA_W'(b_q.ctrl);
            A_STAT:  rd_word = stat_word;
            default: rd_word = '0;
        endcase
    end

    always_comb begin
        b_d = b_q;
        case (state)
            TLR: begin
                b_d.ctrl    = '0;
                b_d.rd_addr = '0;
            end
            CAP_DR: begin
                if (chain_en) b_d.sr = {1'b0, b_q.rd_addr, rd_word};
            end
            SH_DR: begin
                if (chain_en) b_d.sr = {tdi, b_q.sr[CH_W-1:1]};
            end
            UPD_DR: begin
                if (chain_en) begin
                    if (b_q.sr[DIR_BIT]) begin
                        if (scan_addr == A_CTRL) b_d.ctrl = b_q.sr[CTL_W-1:0];
                    end else begin
                        b_d.rd_addr = scan_addr;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) b_q <= '0;
        else         b_q <= b_d;
    end

    assign ctrl_o = b_q.ctrl;
    assign tdo_o  = b_q.sr[0];

endmodule

// File: rtl/dbgscan_top.sv
module dbgscan_top
    import dbgscan_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int SEL_W     = 4,
    parameter int REG_CHAIN = 2
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic core_ack_i,
    input  logic core_sys_done_i,
    input  logic core_narrow_i,
    output logic ack_force_o,
    output logic dbg_req_o,
    output logic irq_mask_o,
    output logic restart_o
);

    tap_state_e       tap_state;
    logic [IR_W-1:0]  ir_cur;
    logic [SEL_W-1:0] sel_cur;
    logic             ir_tdo, sel_tdo, byp_tdo, bank_tdo;
    logic             chain_en, byp_path;
    logic [CTL_W-1:0] ctrl;

    assign chain_en = (ir_cur == IR_INTEST) && (sel_cur == SEL_W'(REG_CHAIN));
    assign byp_path = (ir_cur != IR_SCAN_SEL) && !chain_en;

    dbgscan_tap tap_i (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (tap_state)
    );

    dbgscan_ir #(.SEL_W(SEL_W)) ir_i (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (tap_state),
        .tdi      (tdi),
        .byp_path (byp_path),
        .ir_o     (ir_cur),
        .sel_o    (sel_cur),
        .ir_tdo   (ir_tdo),
        .sel_tdo  (sel_tdo),
        .byp_tdo  (byp_tdo)
    );

    dbgscan_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
        .tck         (tck),
        .trst_n      (trst_n),
        .state       (tap_state),
        .chain_en    (chain_en),
        .tdi         (tdi),
        .core_ack    (core_ack_i),
        .core_sys    (core_sys_done_i),
        .core_narrow (core_narrow_i),
        .ctrl_o      (ctrl),
        .tdo_o       (bank_tdo)
    );

    always_comb begin
        if (tap_state == SH_IR)      tdo = ir_tdo;
        else if (chain_en)           tdo = bank_tdo;
        else if (!byp_path)          tdo = sel_tdo;
        else                         tdo = byp_tdo;
    end

    assign tdo_en      = (tap_state == SH_IR) || (tap_state == SH_DR);
    assign ack_force_o = ctrl[CTL_ACK];
    assign dbg_req_o   = ctrl[CTL_REQ];
    assign irq_mask_o  = ctrl[CTL_IRQ];
    assign restart_o   = (tap_state == RTI) && (ir_cur == IR_RESTART);

endmodule

// File: rtl/dbgscan_chk.sv
module dbgscan_chk
    import dbgscan_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input logic             tck,
    input logic             trst_n,
    input tap_state_e       state,
    input logic [IR_W-1:0]  ir,
    input logic [SEL_W-1:0] sel,
    input logic [CTL_W-1:0] ctrl,
    input logic             restart
);

    // R2
    ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) != UPD_IR && $past(state) != TLR) |-> $stable(ir));

    // R4
    sel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (!($past(state) == UPD_DR && $past(ir) == IR_SCAN_SEL) && $past(state) != TLR)
        |-> $stable(sel));

    // R5
    ctrl_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) != UPD_DR && $past(state) != TLR) |-> $stable(ctrl));

    // R9
    tlr_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == TLR) |-> (ctrl == '0));

    // R11
    restart_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
        restart |-> (ir == IR_RESTART));

endmodule

bind dbgscan_top dbgscan_chk #(.SEL_W(SEL_W)) chk_i (
    .tck     (tck),
    .trst_n  (trst_n),
    .state   (tap_state),
    .ir      (ir_cur),
    .sel     (sel_cur),
    .ctrl    ({irq_mask_o, dbg_req_o, ack_force_o}),
    .restart (restart_o)
);

// File: tb/dbgscan_top_tb_top.sv
`timescale 1ns/1ps
module dbgscan_top_tb_top;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_en;
    logic core_ack = 1'b0, core_sys = 1'b0, core_narrow = 1'b0;
    logic ack_force, dbg_req, irq_mask, restart;

    int checks = 0;
    int errors = 0;

    always #5 tck = ~tck;

    dbgscan_top dut_i (
        .tck             (tck),
        .trst_n          (trst_n),
        .tms             (tms),
        .tdi             (tdi),
        .tdo             (tdo),
        .tdo_en          (tdo_en),
        .core_ack_i      (core_ack),
        .core_sys_done_i (core_sys),
        .core_narrow_i   (core_narrow),
        .ack_force_o     (ack_force),
        .dbg_req_o       (dbg_req),
        .irq_mask_o      (irq_mask),
        .restart_o       (restart)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic a, input logic s, input logic n);
        logic [31:0] v = '0;
        v[0] = a;
        v[3] = s;
        v[4] = n;
        return v;
    endfunction

    function automatic logic [2:0] outs();
        return {irq_mask, dbg_req, ack_force};
    endfunction

    task automatic step(input logic t, input logic d, output logic o);
        @(negedge tck);
        tms = t;
        tdi = d;
        #1;
        o = tdo;
        @(posedge tck);
        #1;
    endtask

    task automatic shift_ir(input logic [3:0] v, output logic [3:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, v[i], o);
            cap[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic reg_scan(input logic dir, input logic [4:0] a, input logic [31:0] d,
                            output logic [37:0] cap);
        logic [63:0] r;
        shift_dr(38, {26'b0, dir, a, d}, r);
        cap = r[37:0];
    endtask

    task automatic pick_chain(input logic [3:0] ch, output logic [3:0] prev);
        logic [3:0]  c;
        logic [63:0] r;
        shift_ir(4'h2, c);
        shift_dr(4, {60'b0, ch}, r);
        prev = r[3:0];
        shift_ir(4'hC, c);
    endtask

    initial begin
        #5_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  c4, prev;
        logic [63:0] r;
        logic [37:0] cap;
        logic [31:0] w;
        logic        o;
        void'($urandom(32'd1234));

        // R1 reset state
        #23;
        chk("R1 outputs in reset", {restart, tdo_en, outs()}, 0);
        @(negedge tck); trst_n = 1'b1;
        step(1, 0, o);
        chk("R1 outputs after reset", {restart, tdo_en, outs()}, 0);
        step(0, 0, o);
        // R1 / R3 bypass after reset
        shift_dr(8, 64'hA5, r);
        chk("R3 bypass delay", r[7:0], 8'h4A);

        // R2 IR capture pattern
        shift_ir(4'h2, c4);
        chk("R2 ir capture", c4, 4'b0001);
        // R4 selector capture and update
        shift_dr(4, 64'h2, r);
        chk("R4 sel capture after reset", r[3:0], 4'h0);
        shift_dr(4, 64'h2, r);
        chk("R4 sel loaded", r[3:0], 4'h2);
        shift_ir(4'hC, c4);
        chk("R2 ir capture again", c4, 4'b0001);

        // R5 directed write
        reg_scan(1, 5'd0, 32'h0000_0002, cap);
        chk("R5 request only", outs(), 3'b010);

        // R8 unimplemented and status writes ignored
        reg_scan(1, 5'd5, 32'hFFFF_FFFF, cap);
        chk("R8 write addr5 ignored", outs(), 3'b010);
        reg_scan(1, 5'd1, 32'hFFFF_FFFF, cap);
        chk("R8 write status ignored", outs(), 3'b010);
        reg_scan(1, 5'd31, 32'hFFFF_FFFF, cap);
        chk("R8 write addr31 ignored", outs(), 3'b010);
        reg_scan(0, 5'd31, 0, cap);
        reg_scan(0, 5'd0, 0, cap);
        chk("R8 read addr31 zero", cap, {1'b0, 5'd31, 32'h0});

        // R6 write keeps latched address
        core_ack = 1'b1; core_sys = 1'b0; core_narrow = 1'b1;
        reg_scan(0, 5'd1, 0, cap);
        reg_scan(1, 5'd0, 32'h5, cap);
        chk("R5 write 5", outs(), 3'b101);
        reg_scan(0, 5'd0, 0, cap);
        chk("R6 addr kept over write", cap, {1'b0, 5'd1, exp_status(1, 0, 1)});

        // random traffic R5 R6 R7
        for (int k = 0; k < 40; k++) begin
            w = $urandom;
            core_ack = 1'($urandom); core_sys = 1'($urandom); core_narrow = 1'($urandom);
            reg_scan(1, 5'd0, w, cap);
            chk("R5 random write", outs(), w[2:0]);
            reg_scan(0, 5'd0, 0, cap);
            reg_scan(0, 5'd1, 0, cap);
            chk("R6 control readback", cap, {1'b0, 5'd0, 29'b0, w[2:0]});
            reg_scan(0, 5'd0, 0, cap);
            chk("R7 status readback", cap, {1'b0, 5'd1, exp_status(core_ack, core_sys, core_narrow)});
        end

        // R10 other chain under internal test
        reg_scan(1, 5'd0, 32'h3, cap);
        pick_chain(4'h1, prev);
        chk("R4 sel capture chain2", prev, 4'h2);
        shift_dr(38, {26'b0, 1'b1, 5'd0, 32'h4}, r);
        chk("R10 bypass shape", r[37:0], {1'b1, 5'd0, 32'h4, 1'b0} & 38'h3F_FFFF_FFFF);
        chk("R10 outputs untouched", outs(), 3'b011);

        // R11 restart strobe
        shift_ir(4'h4, c4);
        chk("R11 restart in idle", restart, 1'b1);
        step(1, 0, o);
        chk("R11 restart off outside idle", restart, 1'b0);
        step(1, 0, o); step(1, 0, o); step(1, 0, o); step(1, 0, o); step(1, 0, o);
        step(0, 0, o);
        chk("R11 restart off after reset path", restart, 1'b0);

        // R9 TLR clears control, IR and selector
        pick_chain(4'h2, prev);
        reg_scan(1, 5'd0, 32'h7, cap);
        chk("R5 all set", outs(), 3'b111);
        for (int i = 0; i < 5; i++) step(1, 0, o);
        chk("R9 control cleared", outs(), 3'b000);
        step(0, 0, o);
        shift_dr(8, 64'h3C, r);
        chk("R9 ir back to bypass", r[7:0], 8'h78);
        pick_chain(4'h2, prev);
        chk("R9 selector cleared", prev, 4'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule